// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and sorts them onto two kinds of output. Sources that are enabled and not marked for pass-through are ORed into one cascade request. That request is meant for a single input of a primary controller, normally its highest-numbered input. A source marked for pass-through leaves the cascade and drives its own output line. That line has the same index as the source and goes straight to the primary input of the same number. Only a parameterised subset of sources can be passed through. The default subset is bits 20 and 22 to 31. Every other source, including the low-numbered ones, reaches the primary controller only through the cascade.

Software sees a small word-addressed register port. The enable mask cannot be written directly. It changes only through a set port, where each 1 bit sets that enable, and a clear port, where each 1 bit clears that enable. A status register returns the pending sources that are enabled, whether or not they are passed through. A raw register returns the source levels as they are. A pass-through register holds the steering bits. Both outputs and the read data are registered.

Top module: `sic_cascade`

## Requirements
- R1: On a synchronous active-high reset the enable mask and the pass-through mask clear to zero. The cascade output and all direct outputs go low.
- R2: A write to word address 2 (enable-set) sets every enable bit whose write-data bit is 1. Zero bits leave their enables unchanged. A read of address 2 or 3 returns the enable mask.
- R3: A write to word address 3 (enable-clear) clears every enable bit whose write-data bit is 1. Zero bits leave their enables unchanged.
- R4: A read of address 0 returns source AND enable. A read of address 1 returns the raw source levels.
- R5: The cascade output is high one cycle after any source is high, enabled and not passed through, and low otherwise.
- R6: Direct output i is high one cycle after source i is high while pass-through bit i is set, whatever the enable bit is.
- R7: The pass-through register at address 4 keeps only the bits allowed by the capability mask (default 0xFFD00000). Other bits read 0, never drive a direct output, and leave their source on the cascade.
- R8: A passed-through source still shows in the status read when it is enabled, but it does not raise the cascade output.
- R9: Sources are level-sensitive: when a source drops, the outputs it drove fall one cycle later, with no latching.
- R10: Read data appears in the cycle after the read strobe. Unmapped addresses (5 to 7) read zero, and the read data is zero in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src | input | 32 | Level interrupt sources |
| cascade_irq | output | 1 | Combined request for the primary controller |
| direct_irq | output | 32 | Per-source pass-through requests |

## Verification
Each result has a fixed latency. A register write takes effect at the clock edge that samples it, and the outputs reflect the new mask one edge after that. A change on a source reaches cascade_irq and direct_irq at the first edge after the change. Read data is valid just after the edge that samples rd_en. The bench drives every input on the falling edge and samples one nanosecond after the next rising edge, so each check lands in the exact cycle in which the result is due.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_STATUS = 3'd0,
    REG_RAW    = 3'd1,
    REG_EN_SET = 3'd2,
    REG_EN_CLR = 3'd3,
    REG_PASS   = 3'd4
  } sic_reg_e;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int          NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] PASS_CAPABLE = 32'hFFD0_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] en_mask,
  output logic [NUM_SRC-1:0] pt_mask,
  output logic [NUM_SRC-1:0] rdata
);
  sic_reg_e              sel;
  logic [NUM_SRC-1:0]    rd_mux;

  assign sel = sic_reg_e'(addr);

  always_comb begin
    case (sel)
      REG_STATUS: rd_mux = status;
      REG_RAW:    rd_mux = src;
      REG_EN_SET: rd_mux = en_mask;
      REG_EN_CLR: rd_mux = en_mask;
      REG_PASS:   rd_mux = pt_mask;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask <= '0;
      pt_mask <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          REG_EN_SET: en_mask <= en_mask | wdata;
          REG_EN_CLR: en_mask <= en_mask & ~wdata;
          REG_PASS:   pt_mask <= wdata & PASS_CAPABLE;
          default:    ;
        endcase
      end
      rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int          NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] PASS_CAPABLE = 32'hFFD0_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic [NUM_SRC-1:0] pt_mask,
  output logic [NUM_SRC-1:0] status,
  output logic               cascade_irq,
  output logic [NUM_SRC-1:0] direct_irq
);
  logic [NUM_SRC-1:0] direct_d;
  logic [NUM_SRC-1:0] stay_local;

  assign status = src & en_mask;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    if (PASS_CAPABLE[i]) begin : g_pass
      assign direct_d[i]   = src[i] & pt_mask[i];
      assign stay_local[i] = ~pt_mask[i];
    end else begin : g_fixed
      assign direct_d[i]   = 1'b0;
      assign stay_local[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cascade_irq <= 1'b0;
      direct_irq  <= '0;
    end else begin
      cascade_irq <= |(status & stay_local);
      direct_irq  <= direct_d;
    end
  end
endmodule

// File: rtl/sic_cascade.sv
module sic_cascade
  import sic_pkg::*;
#(
  parameter int          NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] PASS_CAPABLE = 32'hFFD0_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_AW-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] rdata,
  input  logic [NUM_SRC-1:0] src,
  output logic               cascade_irq,
  output logic [NUM_SRC-1:0] direct_irq
);
  logic [NUM_SRC-1:0] en_mask;
  logic [NUM_SRC-1:0] pt_mask;
  logic [NUM_SRC-1:0] status;

  sic_regs #(.NUM_SRC(NUM_SRC), .PASS_CAPABLE(PASS_CAPABLE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .src(src), .status(status),
    .en_mask(en_mask), .pt_mask(pt_mask), .rdata(rdata)
  );

  sic_route #(.NUM_SRC(NUM_SRC), .PASS_CAPABLE(PASS_CAPABLE)) u_route (
    .clk(clk), .rst(rst), .src(src), .en_mask(en_mask), .pt_mask(pt_mask),
    .status(status), .cascade_irq(cascade_irq), .direct_irq(direct_irq)
  );
endmodule

// File: rtl/sic_cascade_chk.sv
module sic_cascade_chk
  import sic_pkg::*;
#(
  parameter int          NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] PASS_CAPABLE = 32'hFFD0_0000
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [REG_AW-1:0]  addr,
  input logic [NUM_SRC-1:0] wdata,
  input logic [NUM_SRC-1:0] src,
  input logic               cascade_irq,
  input logic [NUM_SRC-1:0] direct_irq,
  input logic [NUM_SRC-1:0] en_mask,
  input logic [NUM_SRC-1:0] pt_mask
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (en_mask == '0 && pt_mask == '0 && !cascade_irq && direct_irq == '0));

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_EN_SET) |=> ((en_mask & $past(wdata)) == $past(wdata)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_EN_CLR) |=> ((en_mask & $past(wdata)) == '0));

  // R5
  cascade_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (cascade_irq && !$past(rst)) |-> (|($past(src) & $past(en_mask))));

  // R6
  direct_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((direct_irq & ~($past(src) & $past(pt_mask))) == '0));

  // R7
  pass_capable_chk: assert property (@(posedge clk) disable iff (rst)
    ((pt_mask & ~PASS_CAPABLE) == '0) && ((direct_irq & ~PASS_CAPABLE) == '0));
endmodule

bind sic_cascade sic_cascade_chk #(.NUM_SRC(NUM_SRC), .PASS_CAPABLE(PASS_CAPABLE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .src(src),
  .cascade_irq(cascade_irq), .direct_irq(direct_irq),
  .en_mask(en_mask), .pt_mask(pt_mask)
);

// File: tb/sic_cascade_tb.sv
module sic_cascade_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '0;
  logic        cascade_irq;
  logic [31:0] direct_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sic_cascade u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .src(src),
    .cascade_irq(cascade_irq), .direct_irq(direct_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic drive_src(logic [31:0] s);
    @(negedge clk); src = s;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 cascade after reset", {31'd0, cascade_irq}, 32'd0);
    check("R1 direct after reset", direct_irq, 32'd0);
    rd(3'd2, v); check("R1 enable after reset", v, 32'd0);
    rd(3'd4, v); check("R1 pass after reset", v, 32'd0);
  endtask

  task automatic t_set_clear();
    logic [31:0] v;
    wr(3'd2, 32'h0000_00F0);
    rd(3'd2, v); check("R2 set", v, 32'h0000_00F0);
    wr(3'd2, 32'h0000_0003);
    rd(3'd3, v); check("R2 zeros keep", v, 32'h0000_00F3);
    wr(3'd3, 32'h0000_0030);
    rd(3'd2, v); check("R3 clear", v, 32'h0000_00C3);
  endtask

  task automatic t_status();
    logic [31:0] v;
    drive_src(32'hFFFF_0F0F);
    rd(3'd0, v); check("R4 status", v, 32'h0000_0003);
    rd(3'd1, v); check("R4 raw", v, 32'hFFFF_0F0F);
    drive_src(32'h0);
  endtask

  task automatic t_cascade();
    drive_src(32'h0000_0040);
    check("R5 enabled source", {31'd0, cascade_irq}, 32'd1);
    drive_src(32'h0000_0100);
    check("R5 disabled source", {31'd0, cascade_irq}, 32'd0);
    drive_src(32'h0000_0001);
    check("R5 bit0 source", {31'd0, cascade_irq}, 32'd1);
    drive_src(32'h0);
    check("R9 level drop", {31'd0, cascade_irq}, 32'd0);
  endtask

  task automatic t_pass();
    logic [31:0] v;
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R7 capable mask", v, 32'hFFD0_0000);
    wr(3'd2, 32'h0040_0020);
    drive_src(32'h0040_0000);
    check("R8 direct bit22", direct_irq, 32'h0040_0000);
    check("R8 no cascade", {31'd0, cascade_irq}, 32'd0);
    rd(3'd0, v); check("R8 status shows", v, 32'h0040_0000);
    drive_src(32'h0000_0020);
    check("R5 local source", {31'd0, cascade_irq}, 32'd1);
    check("R6 no direct", direct_irq, 32'd0);
    drive_src(32'h8000_0000);
    check("R6 direct ignores enable", direct_irq, 32'h8000_0000);
    check("R6 cascade idle", {31'd0, cascade_irq}, 32'd0);
    drive_src(32'h0);
    check("R9 direct drop", direct_irq, 32'd0);
    wr(3'd2, 32'h0020_0000);
    drive_src(32'h0020_0000);
    check("R7 bit21 direct", direct_irq, 32'd0);
    check("R7 bit21 cascades", {31'd0, cascade_irq}, 32'd1);
    drive_src(32'h0);
  endtask

  task automatic t_read_port();
    logic [31:0] v;
    rd(3'd7, v); check("R10 unmapped", v, 32'd0);
    rd(3'd5, v); check("R10 unmapped 5", v, 32'd0);
    @(posedge clk); #1 check("R10 idle zero", rdata, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_set_clear();
    t_status();
    t_cascade();
    t_pass();
    t_read_port();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule